// File: doc/BRIEF.md
# Frame-Gated Serial Converter Capture

This block receives sample frames from an analog-to-digital converter whose output port is not a chip-select SPI bus. The port has three wires. An active-low ready strobe falls when a frame begins. A data clock runs all the time. A single data line changes on the rising clock edge. The strobe stays low after the useful data ends, while the clock keeps running. During that time the data line sends all-ones filler, and the last byte before the strobe rises is cut short. The block counts clock periods from the strobe's fall and opens a capture window only over a range of bit positions set by parameters. This skips the leading header byte and never lets the trailing junk into the shift register.

Bytes from inside the window pass through a small gray-pointer FIFO into the system clock domain. There they are assembled into a frame of `FRAME_BYTES` bytes. A completed frame is copied in one step into an output buffer, which the host reads through a plain address/data port. A one-cycle pulse marks each completed frame. A second one-cycle pulse marks a strobe that rose before a full frame arrived. Between frames the assembler drops filler bytes and restarts on the first byte that is not filler.

Top module: `frame_gated_capture`

## Requirements
- R1: After reset, `frame_done` and `frame_err` are 0, every output buffer location reads 0x00, and the assembler is in its hunting state.
- R2: Data bits are sampled on the falling edge of `cnv_clk`, most significant bit first. Bit position 0 is the first falling edge at which `cnv_rdy_n` is seen low.
- R3: Bit positions 0 to `WIN_START`-1 of each frame (the header, 8 bits by default) are never captured.
- R4: Bit positions `WIN_END` and later are ignored. The position counter saturates there, so filler, stray bytes and a truncated last byte after the window never reach the output. `WIN_END`-`WIN_START` is a multiple of 8.
- R5: While `cnv_rdy_n` is high, the position counter, the shift register and the per-frame byte count are held cleared. Every low period therefore starts again at position 0.
- R6: When the assembler stores its `FRAME_BYTES`-th byte, all buffer locations are updated together in one system cycle, and `frame_done` is high for exactly that one cycle. At all other times the buffer holds its value.
- R7: In the hunting state (after reset, after a completed frame or after an error), a byte equal to 0xFF is discarded. Any other byte is stored as byte 0 and assembly continues at index 1. Bytes at indices 1 and up are stored whatever their value, 0xFF included.
- R8: If `cnv_rdy_n` rises after fewer than `FRAME_BYTES` window bytes in that low period, `frame_err` pulses for one system cycle. The partial frame is dropped, the buffer is unchanged, and the assembler returns to hunting.
- R9: `frame_done` and `frame_err` are never high in the same cycle, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of both clocks |
| cnv_clk | input | 1 | Free-running converter data clock |
| cnv_rdy_n | input | 1 | Active-low data-ready strobe framing one transfer |
| cnv_dat | input | 1 | Serial data, changes on the rising edge of `cnv_clk` |
| rd_addr | input | $clog2(FRAME_BYTES) | Output buffer byte index |
| rd_data | output | 8 | Output buffer byte at `rd_addr` (0x00 beyond the frame) |
| frame_done | output | 1 | One-cycle pulse when a new frame is in the buffer |
| frame_err | output | 1 | One-cycle pulse on a frame cut short by the strobe |

## Verification
The bench drives the data line on rising edges only. A design that samples on the wrong edge would capture shifted bits and fail every buffer compare. One frame puts a non-filler stray byte just past the window end. If the saturating window leaked, that byte would resynchronise the assembler and the next frame would land rotated. Resynchronisation is tested in three ways: a non-filler byte in the filler region, a stored 0xFF in mid-frame, and a frame whose first data byte is 0xFF while hunting. The expected buffers come out shifted by one place, so an assembler that always restarted at byte 0 or dropped every 0xFF would show. A short frame and a strobe glitch inside the header must raise the error pulse and leave the previous buffer intact. A design that wrote straight into the output array, or that did not clear its counter on the strobe, would corrupt the following frames.

// File: rtl/fgc_pkg.sv
// Shared definitions for the frame-gated capture block.
// Assumes: bytes are 8 bits and the filler value sent after the data is all ones.
package fgc_pkg;
    localparam logic [7:0] FILLER_BYTE = 8'hFF;

    // Event passed from the converter clock domain to the system domain.
    typedef struct packed {
        logic       short_frame;  // strobe rose before a full frame
        logic [7:0] data;         // captured byte (valid when short_frame = 0)
    } fgc_evt_t;

    localparam int EVT_W = $bits(fgc_evt_t);
endpackage

// File: rtl/fgc_window.sv
// Capture window and shifter, clocked on the falling edge of the converter clock.
// Counts bit positions from the ready-strobe fall. It shifts in only the positions
// inside [WIN_START, WIN_END) and emits one event per completed byte. It also emits
// a short-frame event when the strobe rises before FRAME_BYTES bytes were emitted.
// Assumes: (WIN_END - WIN_START) is a multiple of 8; the reset is held across
// several converter clock periods.
module fgc_window
    import fgc_pkg::*;
#(
    parameter int WIN_START   = 8,
    parameter int WIN_END     = 88,
    parameter int FRAME_BYTES = 8
) (
    input  logic     cnv_clk,
    input  logic     rst_n,
    input  logic     rdy_n,
    input  logic     dat,
    output logic     evt_valid,
    output fgc_evt_t evt
);
    localparam int CW  = $clog2(WIN_END + 1);
    localparam int NBW = $clog2(FRAME_BYTES + 1);
    localparam logic [CW-1:0]  START_C = CW'(WIN_START);
    localparam logic [CW-1:0]  END_C   = CW'(WIN_END);
    localparam logic [NBW-1:0] NB_FULL = NBW'(FRAME_BYTES);

    logic [CW-1:0]  pos;
    logic [6:0]     shreg;
    logic [NBW-1:0] nbytes;
    logic           rdy_q;
    logic           in_win;
    logic [2:0]     rel3;
    logic           byte_end;
    logic           short_hit;

    // Decode whether the current position lies inside the window and ends a byte.
    always_comb begin
        in_win    = !rdy_n && (pos >= START_C) && (pos < END_C);
        rel3      = pos[2:0] - START_C[2:0];
        byte_end  = in_win && (rel3 == 3'd7);
        short_hit = rdy_n && !rdy_q && (nbytes < NB_FULL);
    end

    // Build the event for the crossing FIFO.
    always_comb begin
        evt_valid       = byte_end || short_hit;
        evt.short_frame = short_hit;
        evt.data        = byte_end ? {shreg, dat} : 8'h00;
    end

    // Position counter: cleared while the strobe is high, saturates at the window end.
    always_ff @(negedge cnv_clk) begin
        if (!rst_n || rdy_n) begin
            pos <= '0;
        end else if (pos < END_C) begin
            pos <= pos + 1'b1;
        end
    end

    // Shift register: loads bits only inside the window, cleared between frames.
    always_ff @(negedge cnv_clk) begin
        if (!rst_n || rdy_n) begin
            shreg <= '0;
        end else if (in_win) begin
            shreg <= {shreg[5:0], dat};
        end
    end

    // Bytes emitted in this low period, used to detect a frame cut short.
    always_ff @(negedge cnv_clk) begin
        if (!rst_n || rdy_n) begin
            nbytes <= '0;
        end else if (byte_end && nbytes < NB_FULL) begin
            nbytes <= nbytes + 1'b1;
        end
    end

    // Previous strobe level for rising-edge detection.
    always_ff @(negedge cnv_clk) begin
        if (!rst_n) rdy_q <= 1'b1;
        else        rdy_q <= rdy_n;
    end
endmodule

// File: rtl/fgc_cdc_fifo.sv
// Dual-clock FIFO with gray-coded pointers and two-stage synchronisers.
// The writer runs on the falling edge of the converter clock, the reader on the
// rising edge of the system clock. Writes when full are dropped.
// Assumes: AW >= 2 and a reader fast enough to drain at the byte rate.
module fgc_cdc_fifo #(
    parameter int DW = 9,
    parameter int AW = 2
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rclk,
    input  logic          rd_en,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wbin, wgray, rbin, rgray;
    logic [AW:0]   rg_w1, rg_w2;   // read pointer seen in write domain
    logic [AW:0]   wg_r1, wg_r2;   // write pointer seen in read domain
    logic          full;
    logic [AW:0]   wbin_nx, rbin_nx;

    // Full and empty flags from the synchronised gray pointers.
    always_comb begin
        full     = (wgray == {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});
        rd_valid = (rgray != wg_r2);
        rd_data  = mem[rbin[AW-1:0]];
        wbin_nx  = wbin + 1'b1;
        rbin_nx  = rbin + 1'b1;
    end

    // Storage write in the converter domain.
    always_ff @(negedge wclk) begin
        if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
    end

    // Write pointer update.
    always_ff @(negedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en && !full) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Read pointer brought into the write domain.
    always_ff @(negedge wclk) begin
        if (!rst_n) begin
            rg_w1 <= '0;
            rg_w2 <= '0;
        end else begin
            rg_w1 <= rgray;
            rg_w2 <= rg_w1;
        end
    end

    // Read pointer update.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en && rd_valid) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Write pointer brought into the read domain.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            wg_r1 <= '0;
            wg_r2 <= '0;
        end else begin
            wg_r1 <= wgray;
            wg_r2 <= wg_r1;
        end
    end
endmodule

// File: rtl/fgc_assembler.sv
// Frame assembler in the system domain. It collects bytes into a work area and
// copies a full frame into the output buffer in one cycle. While hunting it drops
// filler bytes and restarts on a short-frame event. It pulses done or error.
// Assumes: FRAME_BYTES is a power of two, at least 2.
module fgc_assembler
    import fgc_pkg::*;
#(
    parameter int FRAME_BYTES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  fgc_evt_t                       in_evt,
    input  logic [$clog2(FRAME_BYTES)-1:0] rd_addr,
    output logic [7:0]                     rd_data,
    output logic                           frame_done,
    output logic                           frame_err
);
    localparam int AW = $clog2(FRAME_BYTES);
    localparam int IW = $clog2(FRAME_BYTES + 1);
    localparam int LAST = FRAME_BYTES - 1;
    localparam logic [IW-1:0] HUNT   = IW'(FRAME_BYTES);
    localparam logic [IW-1:0] LAST_I = IW'(LAST);

    logic [7:0]    work  [FRAME_BYTES];
    logic [7:0]    frame [FRAME_BYTES];
    logic [IW-1:0] idx;
    logic          take_first, take_next, finish;

    // Classify the incoming event against the assembly state.
    always_comb begin
        take_first = in_valid && !in_evt.short_frame && (idx == HUNT)
                     && (in_evt.data != FILLER_BYTE);
        take_next  = in_valid && !in_evt.short_frame && (idx != HUNT);
        finish     = take_next && (idx == LAST_I);
    end

    // Assembly index: hunting, or the next position to fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= HUNT;
        end else if (in_valid && in_evt.short_frame) begin
            idx <= HUNT;
        end else if (take_first) begin
            idx <= IW'(1);
        end else if (finish) begin
            idx <= HUNT;
        end else if (take_next) begin
            idx <= idx + 1'b1;
        end
    end

    // Work area write.
    always_ff @(posedge clk) begin
        if (take_first)                 work[0] <= in_evt.data;
        else if (take_next && !finish)  work[idx[AW-1:0]] <= in_evt.data;
    end

    // Output buffer: whole-frame copy on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FRAME_BYTES; i++) frame[i] <= 8'h00;
        end else if (finish) begin
            for (int i = 0; i < LAST; i++) frame[i] <= work[i];
            frame[LAST] <= in_evt.data;
        end
    end

    // Status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            frame_done <= finish;
            frame_err  <= in_valid && in_evt.short_frame;
        end
    end

    // Host read port.
    always_comb rd_data = frame[rd_addr];
endmodule

// File: rtl/frame_gated_capture.sv
// Top level: window/shifter in the converter clock domain, crossing FIFO,
// frame assembler in the system domain.
// Assumes: the system clock is at least several times the byte rate, and rst_n
// is held for several periods of both clocks.
module frame_gated_capture
    import fgc_pkg::*;
#(
    parameter int WIN_START   = 8,
    parameter int FRAME_BYTES = 8,
    parameter int WIN_END     = 88,
    parameter int FIFO_AW     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cnv_clk,
    input  logic                           cnv_rdy_n,
    input  logic                           cnv_dat,
    input  logic [$clog2(FRAME_BYTES)-1:0] rd_addr,
    output logic [7:0]                     rd_data,
    output logic                           frame_done,
    output logic                           frame_err
);
    localparam int ADDR_W = $clog2(FRAME_BYTES);

    logic     w_valid, r_valid;
    fgc_evt_t w_evt, r_evt;
    logic [EVT_W-1:0] r_raw;

    fgc_window #(
        .WIN_START  (WIN_START),
        .WIN_END    (WIN_END),
        .FRAME_BYTES(FRAME_BYTES)
    ) u_win (
        .cnv_clk  (cnv_clk),
        .rst_n    (rst_n),
        .rdy_n    (cnv_rdy_n),
        .dat      (cnv_dat),
        .evt_valid(w_valid),
        .evt      (w_evt)
    );

    fgc_cdc_fifo #(
        .DW(EVT_W),
        .AW(FIFO_AW)
    ) u_fifo (
        .wclk    (cnv_clk),
        .rst_n   (rst_n),
        .wr_en   (w_valid),
        .wr_data (w_evt),
        .rclk    (clk),
        .rd_en   (r_valid),
        .rd_valid(r_valid),
        .rd_data (r_raw)
    );

    // Reinterpret the FIFO word as an event.
    always_comb r_evt = fgc_evt_t'(r_raw);

    fgc_assembler #(
        .FRAME_BYTES(FRAME_BYTES)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (r_valid),
        .in_evt    (r_evt),
        .rd_addr   (rd_addr[ADDR_W-1:0]),
        .rd_data   (rd_data),
        .frame_done(frame_done),
        .frame_err (frame_err)
    );
endmodule

// File: rtl/frame_gated_capture_chk.sv
// Port-level checker for frame_gated_capture, attached with bind.
module frame_gated_capture_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    rd_data,
    input logic          frame_done,
    input logic          frame_err
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);                                        // R6
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);                                          // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_err));                                        // R9
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && $stable(rd_addr)) |-> $stable(rd_data));            // R6
    AST_ERR_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && $stable(rd_addr)) |-> $stable(rd_data));              // R8
endmodule

bind frame_gated_capture frame_gated_capture_chk #(.AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .frame_done(frame_done),
    .frame_err (frame_err)
);

// File: tb/frame_gated_capture_tb.sv
module frame_gated_capture_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int CNV_PERIOD  = 40;
    localparam int FRAME_BYTES = 8;

    logic       clk = 1'b0, cnv_clk = 1'b1, rst_n = 1'b0;
    logic       cnv_rdy_n = 1'b1, cnv_dat = 1'b1;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       frame_done, frame_err;

    int n_chk = 0, n_fail = 0, n_done = 0, n_err = 0, n_overlap = 0;
    bit finished = 0;
    logic       stream [512];
    int         slen;
    logic [7:0] exp_buf [FRAME_BYTES];

    frame_gated_capture u_dut (
        .clk(clk), .rst_n(rst_n), .cnv_clk(cnv_clk), .cnv_rdy_n(cnv_rdy_n),
        .cnv_dat(cnv_dat), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_done(frame_done), .frame_err(frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(CNV_PERIOD/2) cnv_clk = ~cnv_clk;

    // Pulse counters, sampled mid-cycle.
    always @(negedge clk) begin
        if (frame_done) n_done++;
        if (frame_err)  n_err++;
        if (frame_done && frame_err) n_overlap++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            stream[slen] = b[i];
            slen++;
        end
    endtask

    task automatic put_bits(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            stream[slen] = v;
            slen++;
        end
    endtask

    // Drive the stream while the strobe is low; changes on rising edges only.
    task automatic play();
        @(posedge cnv_clk); #1;
        cnv_rdy_n = 1'b0;
        cnv_dat   = stream[0];
        for (int k = 1; k < slen; k++) begin
            @(posedge cnv_clk); #1;
            cnv_dat = stream[k];
        end
        @(posedge cnv_clk); #1;
        cnv_rdy_n = 1'b1;
        cnv_dat   = 1'b1;
        repeat (6) @(posedge cnv_clk);
        repeat (20) @(posedge clk);
        slen = 0;
    endtask

    task automatic check_buf(input string req);
        for (int a = 0; a < FRAME_BYTES; a++) begin
            @(negedge clk);
            rd_addr = 3'(a);
            @(negedge clk);
            check(req, rd_data, exp_buf[a]);
        end
    endtask

    task automatic set_exp(input logic [63:0] v);
        for (int a = 0; a < FRAME_BYTES; a++) exp_buf[a] = v[63-8*a -: 8];
    endtask

    task automatic frame_bytes(input logic [63:0] v);
        for (int a = 0; a < FRAME_BYTES; a++) put_byte(v[63-8*a -: 8]);
    endtask

    // R1: reset state.
    task automatic t_reset();
        check("R1 done", frame_done, 0);
        check("R1 err", frame_err, 0);
        set_exp(64'h0);
        check_buf("R1 buffer");
    endtask

    // R2 R3 R4 R6: header skipped, falling-edge sampling, filler and tail ignored.
    task automatic t_normal();
        put_byte(8'h5A);
        frame_bytes(64'h81024418C37E0099);
        put_byte(8'hFF); put_byte(8'hFF);
        put_bits(5, 1'b1);
        play();
        check("R6 done count", n_done, 1);
        check("R8 no err", n_err, 0);
        set_exp(64'h81024418C37E0099);
        check_buf("R2/R3 buffer");
    endtask

    // R4: stray non-filler byte beyond the window end must not resync.
    task automatic t_beyond();
        put_byte(8'h00);
        frame_bytes(64'h1020304050607080);
        put_byte(8'hFF); put_byte(8'hFF);
        put_byte(8'h12);
        put_bits(4, 1'b0);
        play();
        check("R4 done count", n_done, 2);
        set_exp(64'h1020304050607080);
        check_buf("R4 buffer");
    endtask

    // R7: 0xFF stored mid-frame, non-filler in filler region resyncs.
    task automatic t_resync();
        put_byte(8'hC0);
        frame_bytes(64'h0F1E2D3C4B5A69FF);
        put_byte(8'hFF); put_byte(8'h6B);
        put_bits(6, 1'b1);
        play();
        check("R7 done count a", n_done, 3);
        set_exp(64'h0F1E2D3C4B5A69FF);
        check_buf("R7 buffer mid FF");
        put_byte(8'h11);
        frame_bytes(64'hA1A2A3A4A5A6A7FF);
        put_byte(8'hFF); put_byte(8'hFF);
        play();
        check("R7 done count b", n_done, 4);
        set_exp(64'h6BA1A2A3A4A5A6A7);
        check_buf("R7 resync buffer");
    endtask

    // R8: short frame raises error, keeps buffer, returns to hunting.
    task automatic t_short();
        put_byte(8'h22);
        put_byte(8'h55); put_byte(8'h66); put_byte(8'h77);
        put_bits(3, 1'b1);
        play();
        check("R8 err count", n_err, 1);
        check("R8 done unchanged", n_done, 4);
        check_buf("R8 buffer held");
        put_byte(8'h33);
        frame_bytes(64'h0102030405060708);
        put_byte(8'hFF); put_byte(8'hFF);
        play();
        check("R8 recover done", n_done, 5);
        set_exp(64'h0102030405060708);
        check_buf("R8 recover buffer");
    endtask

    // R5: strobe glitch inside header, then counter must restart at position 0.
    task automatic t_glitch();
        put_bits(4, 1'b0);
        play();
        check("R5 glitch err", n_err, 2);
        check("R5 glitch done", n_done, 5);
        put_byte(8'h44);
        frame_bytes(64'hFFB1B2B3B4B5B6B7);
        put_byte(8'hFF); put_byte(8'hFF);
        play();
        check("R7 leading FF done", n_done, 6);
        set_exp(64'hB1B2B3B4B5B6B7FF);
        check_buf("R7 leading FF buffer");
        put_byte(8'h45);
        frame_bytes(64'hC1C2C3C4C5C6C7C8);
        put_byte(8'hFF); put_byte(8'hFF);
        put_bits(7, 1'b1);
        play();
        check("R5 done", n_done, 7);
        set_exp(64'hC1C2C3C4C5C6C7C8);
        check_buf("R5 buffer");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        slen = 0;
        repeat (10) @(posedge cnv_clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(posedge cnv_clk);
        t_normal();
        t_beyond();
        t_resync();
        t_short();
        t_glitch();
        check("R9 overlap", n_overlap, 0);
        check("R9 final err", n_err, 2);
        finish_run();
    end
endmodule